// File: doc/BRIEF.md
# Four-and-a-half decade event counter

This block counts events on a single digital count line and holds the total as four BCD decades plus a sticky half-digit flag, so the largest value it can show is 19999. Everything runs on one system clock. The count line, the inhibit line and the clear line are brought into the clock domain through flop synchronisers. One count is taken on each falling transition of the synchronised count line.

An active-low inhibit freezes the first counting stage. The edge detector keeps tracking the count line while the inhibit is held, so neither asserting nor releasing the inhibit can create a false count. An active-low clear zeroes the decades and the half-digit flag. Each time the decades wrap from 9999 to 0000, an active-low carry output pulses for one clock, so several blocks can be chained into a longer counter. The first wrap also sets the half-digit flag, which then stays set until a clear while the decades keep counting.

Top module: `evc_counter`

## Requirements
- R1: After the system reset the digits read 0000, the half-digit flag is 0 and the carry output is high.
- R2: Each falling transition of the count input adds exactly one to the value, and rising transitions add nothing. The new value is visible three clocks after the input changes (two synchroniser flops and one counter flop).
- R3: Each decade holds 0 to 9 and moves from 9 to 0 while stepping the next decade up. Decade i sits in bits 4*i+3 down to 4*i of the digit output, so decade 0 is the least significant.
- R4: The step from 9999 to 0000 drives the carry output low for exactly one clock, starting on the same clock in which the digits become 0000.
- R5: The first wrap from 9999 sets the half-digit flag. The flag stays set through later counts and later wraps until a clear.
- R6: While the inhibit input is low, falling transitions of the count input are ignored. Releasing the inhibit while the count input is low does not produce a count.
- R7: A low level on the clear input zeroes all decades and the half-digit flag. It wins over a count in the same cycle.
- R8: The value 19999 is reachable: the half-digit flag is 1 and all four decades read 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| count_i | input | 1 | Event input, counted on its falling transition |
| count_inhibit_n_i | input | 1 | Inhibit, active low, freezes the first stage |
| clear_n_i | input | 1 | Counter clear, active low, synchronised |
| bcd_o | output | 16 | Four BCD decades, decade 0 in bits 3:0 |
| half_o | output | 1 | Sticky half-digit / overflow flag |
| carry_n_o | output | 1 | One-clock low pulse on each 9999 wrap |

## Verification
The assertions assume that the count line holds each level for at least two system clocks, so that every falling transition shows up as one pulse on the internal advance event. They also assume that the clear and inhibit lines change no faster than the synchroniser can follow. The stimulus holds every level of the count input for two clocks. It changes the inhibit and clear lines only at falling clock edges and holds each new level for several clocks. As a result, every single-step and hold-still property checks a count that the input really made.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int DIGIT_W = 4;
  localparam int DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // next value of one decade, wrapping 9 to 0
  function automatic bcd_t bcd_next(input bcd_t d);
    if (d >= bcd_t'(DIGIT_MAX)) return '0;
    return d + bcd_t'(1);
  endfunction

  // decade is at its terminal value
  function automatic logic bcd_is_max(input bcd_t d);
    return d == bcd_t'(DIGIT_MAX);
  endfunction
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/evc_front.sv
// Falling-edge detection with a true inhibit: the edge history always
// follows the count line, only the resulting step is suppressed.
module evc_front (
  input  logic clk,
  input  logic rst_n,
  input  logic count_s,
  input  logic inhibit_n_s,
  output logic advance_o
);
  logic count_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_d <= 1'b1;
    else count_d <= count_s;
  end

  assign advance_o = count_d & ~count_s & inhibit_n_s;
endmodule

// File: rtl/evc_decade.sv
module evc_decade
  import evc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output bcd_t digit_o,
  output logic tc_o
);
  bcd_t digit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) digit_q <= '0;
    else if (clr_i) digit_q <= '0;
    else if (en_i) digit_q <= bcd_next(digit_q);
  end

  assign digit_o = digit_q;
  assign tc_o    = en_i & bcd_is_max(digit_q);
endmodule

// File: rtl/evc_overflow.sv
module evc_overflow (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic wrap_i,
  output logic half_o,
  output logic carry_n_o
);
  logic half_q;
  logic carry_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      carry_n_q <= 1'b1;
    end else if (clr_i) begin
      half_q    <= 1'b0;
      carry_n_q <= 1'b1;
    end else begin
      half_q    <= half_q | wrap_i;
      carry_n_q <= ~wrap_i;
    end
  end

  assign half_o    = half_q;
  assign carry_n_o = carry_n_q;
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int NUM_DECADES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           count_i,
  input  logic                           count_inhibit_n_i,
  input  logic                           clear_n_i,
  output logic [NUM_DECADES*DIGIT_W-1:0] bcd_o,
  output logic                           half_o,
  output logic                           carry_n_o
);
  localparam int N_CTRL = 3;

  logic [N_CTRL-1:0] ctrl_raw;
  logic [N_CTRL-1:0] ctrl_s;
  logic              count_s;
  logic              inhibit_n_s;
  logic              clr_s;
  logic              advance;
  logic              wrap;
  logic [NUM_DECADES:0] stage_en;

  assign ctrl_raw = {clear_n_i, count_inhibit_n_i, count_i};

  evc_sync #(.WIDTH(N_CTRL), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (ctrl_raw),
    .q_o  (ctrl_s)
  );

  assign count_s     = ctrl_s[0];
  assign inhibit_n_s = ctrl_s[1];
  assign clr_s       = ~ctrl_s[2];

  evc_front u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_s    (count_s),
    .inhibit_n_s(inhibit_n_s),
    .advance_o  (advance)
  );

  assign stage_en[0] = advance & ~clr_s;

  generate
    for (genvar i = 0; i < NUM_DECADES; i++) begin : g_decade
      bcd_t digit;
      evc_decade u_decade (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_s),
        .en_i   (stage_en[i]),
        .digit_o(digit),
        .tc_o   (stage_en[i+1])
      );
      assign bcd_o[i*DIGIT_W +: DIGIT_W] = digit;
    end
  endgenerate

  assign wrap = stage_en[NUM_DECADES];

  evc_overflow u_overflow (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_s),
    .wrap_i   (wrap),
    .half_o   (half_o),
    .carry_n_o(carry_n_o)
  );
endmodule

// File: rtl/evc_checker.sv
module evc_checker
  import evc_pkg::*;
#(
  parameter int NUM_DECADES = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           advance,
  input logic                           clr_s,
  input logic [NUM_DECADES*DIGIT_W-1:0] bcd_o,
  input logic                           half_o,
  input logic                           carry_n_o
);
  function automatic logic digits_ok(input logic [NUM_DECADES*DIGIT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DECADES; i++)
      if (v[i*DIGIT_W +: DIGIT_W] > bcd_t'(DIGIT_MAX)) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint to_num(input logic [NUM_DECADES*DIGIT_W-1:0] v);
    longint n;
    n = 0;
    for (int i = NUM_DECADES-1; i >= 0; i--)
      n = n*10 + longint'(v[i*DIGIT_W +: DIGIT_W]);
    return n;
  endfunction

  function automatic logic all_max(input logic [NUM_DECADES*DIGIT_W-1:0] v);
    return to_num(v) == to_num({NUM_DECADES{4'd9}});
  endfunction

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(bcd_o)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clr_s && !all_max(bcd_o)) |=> (to_num(bcd_o) == to_num($past(bcd_o)) + 1)); // R2
  AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |=> carry_n_o); // R4
  AST_CARRY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n_o |-> (bcd_o == '0 && half_o)); // R4
  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (half_o && !clr_s) |=> half_o); // R5
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clr_s) |=> $stable(bcd_o)); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (bcd_o == '0 && !half_o && carry_n_o)); // R7
endmodule

bind evc_counter evc_checker #(.NUM_DECADES(NUM_DECADES)) u_evc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .advance  (advance),
  .clr_s    (clr_s),
  .bcd_o    (bcd_o),
  .half_o   (half_o),
  .carry_n_o(carry_n_o)
);

// File: tb/test_evc_counter.sv
module test_evc_counter;
  typedef struct {
    int    value;
    bit    half;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_i = 1'b1;
  logic        inh_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [15:0] bcd_o;
  logic        half_o;
  logic        carry_n_o;

  int   n_checks = 0;
  int   n_fail = 0;
  int   ref_cnt = 0;
  bit   ref_half = 0;
  int   carry_pulses = 0;
  bit   carry_prev = 1'b1;
  bit   done = 0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  evc_counter i_evc_counter (
    .clk(clk), .rst_n(rst_n), .count_i(count_i),
    .count_inhibit_n_i(inh_n), .clear_n_i(clr_n),
    .bcd_o(bcd_o), .half_o(half_o), .carry_n_o(carry_n_o)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.value = ref_cnt;
    e.half = ref_half;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // one full count pulse: two clocks low, two high
  task automatic pulse_count(input bit counts);
    @(negedge clk) count_i = 1'b0;
    repeat (2) @(negedge clk);
    count_i = 1'b1;
    repeat (2) @(negedge clk);
    if (counts) begin
      if (ref_cnt == 9999) begin
        ref_cnt = 0;
        ref_half = 1'b1;
      end else ref_cnt++;
    end
  endtask

  // monitor: pop and compare at falling edges
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(bcd_o == to_bcd(e.value) && half_o == e.half, e.tag,
            $sformatf("actual %h/%0b expected %h/%0b", bcd_o, half_o, to_bcd(e.value), e.half));
    end
    if (rst_n && !carry_n_o) begin
      check(carry_prev, "R4", "carry low for more than one clock (actual 0, expected 1)");
      check(bcd_o == 16'h0000, "R4", $sformatf("digits during carry actual %h expected 0000", bcd_o));
      if (carry_prev) carry_pulses++;
    end
    carry_prev = carry_n_o;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bcd_o == 16'h0 && half_o == 1'b0 && carry_n_o == 1'b1, "R1",
          $sformatf("reset actual %h/%0b/%0b expected 0000/0/1", bcd_o, half_o, carry_n_o));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release, R2 single counts
    push("R1");
    for (int i = 0; i < 12; i++) begin
      pulse_count(1);
      push((ref_cnt % 10 == 0) ? "R3" : "R2");
    end
    // R6: inhibit freezes, toggling and release while low give nothing
    @(negedge clk) inh_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) pulse_count(0);
    @(negedge clk) count_i = 1'b0;
    repeat (4) @(negedge clk);
    inh_n = 1'b1;
    repeat (4) @(negedge clk);
    count_i = 1'b1;
    repeat (4) @(negedge clk);
    push("R6");
    pulse_count(1);
    push("R2");
    // R7: clear coincident with a falling count
    @(negedge clk);
    clr_n = 1'b0;
    count_i = 1'b0;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    count_i = 1'b1;
    repeat (4) @(negedge clk);
    ref_cnt = 0;
    ref_half = 0;
    push("R7");
    // count to 9999, then wrap (R3, R4, R5)
    for (int i = 0; i < 9999; i++) begin
      pulse_count(1);
      push((ref_cnt % 10 == 0) ? "R3" : "R2");
    end
    check(bcd_o == 16'h9999, "R3", $sformatf("actual %h expected 9999", bcd_o));
    pulse_count(1);
    push("R5");
    repeat (2) @(negedge clk);
    check(carry_pulses == 1, "R4", $sformatf("carry pulses actual %0d expected 1", carry_pulses));
    // keep counting to 19999 and through a second wrap
    for (int i = 0; i < 9999; i++) begin
      pulse_count(1);
      push(ref_cnt == 9999 ? "R8" : "R5");
    end
    check(bcd_o == 16'h9999 && half_o, "R8", $sformatf("actual %0b%h expected 19999", half_o, bcd_o));
    pulse_count(1);
    push("R5");
    repeat (2) @(negedge clk);
    check(carry_pulses == 2, "R4", $sformatf("carry pulses actual %0d expected 2", carry_pulses));
    check(half_o == 1'b1, "R5", $sformatf("half after second wrap actual %0b expected 1", half_o));
    // R7: clear drops the sticky flag
    @(negedge clk) clr_n = 1'b0;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    ref_cnt = 0;
    ref_half = 0;
    push("R7");
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!done && cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) check(1'b0, "watchdog", "run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule